// File: doc/BRIEF.md
# Two-Common Multiplexed LCD Segment Driver

This block drives a multiplexed liquid-crystal panel that has two common electrodes and up to 28 segment electrodes, giving 56 addressable segments. Each segment electrode carries two pattern bits, one per common. Software-side logic writes them one digit at a time, where a digit is a group of adjacent segment lines. The block runs its own frame timer and turns the stored pattern into a per-pin drive level code. An external analog stage converts these codes into the actual high, middle and low electrode voltages.

A frame is split into four equal slots. In the first two slots the first common is driven high and then low, while the second common rests at the middle level. In the last two slots the roles are swapped. A segment that should be visible drives the level opposite to the active common. A segment that should stay dark drives the same level as the active common, so it sees no net voltage. New patterns are staged and only take effect at a frame boundary, so a frame never shows a half-updated picture.

While reset is held, every segment shows the dark waveform and the commons keep cycling. A backup input pulls every electrode low. The topmost segment lines can be switched as a group to act as plain output bits.

Top module: `lcd_halfbias_driver`

## Requirements
- R1: One frame lasts CLK_HZ/FRAME_HZ clock cycles and has four slots of CLK_HZ/(4*FRAME_HZ) cycles each. With the bench values of 4000 and 100 that is 40 and 10 cycles. The timer runs freely and reset does not stop it.
- R2: Common level codes are LOW=2'b00, MID=2'b01 and HIGH=2'b10. Across the four slots, com1 goes HIGH, LOW, MID, MID and com2 goes MID, MID, HIGH, LOW. Outside backup, at least one common is always MID, and the code 2'b11 never appears.
- R3: Segment pins use the code 1 for high and 0 for low. In slots 0 and 1 a segment follows its phase-0 bit, and in slots 2 and 3 its phase-1 bit. A set bit drives the level opposite to the active common and a clear bit drives the same level. So in slot 0 the pin is the inverse of the bit, in slot 1 it equals the bit, in slot 2 it is the inverse of the phase-1 bit, and in slot 3 it equals that bit.
- R4: A write with index d < NDIG loads both phase nibbles of digit d. Digit d covers segment lines d*DIGIT_W up to d*DIGIT_W+DIGIT_W-1, and nibble bit i maps to line d*DIGIT_W+i. All other digits keep their pattern.
- R5: A written pattern first appears in the frame that starts after the write. The rest of the current frame still shows the old pattern.
- R6: While rst_i is high, every segment shows the dark waveform: 1 in slots 0 and 2, 0 in slots 1 and 3. The commons keep their normal sequence, and all stored patterns are cleared.
- R7: One cycle after bkup_i is high, both commons are LOW and every segment pin is 0. The stored pattern survives backup.
- R8: With gp_sel_i high, and neither reset nor backup active, the top PORT_SEGS segment pins output port_i one cycle later. The lower pins keep their LCD waveform.
- R9: A write whose digit index is NDIG or above has no effect on any segment pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset, blanks the segments |
| bkup_i | input | 1 | Backup mode, all pins driven low |
| wr_en_i | input | 1 | Digit write strobe |
| wr_dig_i | input | DIG_AW | Digit index of the write |
| wr_ph0_i | input | DIGIT_W | Pattern bits shown against com1 |
| wr_ph1_i | input | DIGIT_W | Pattern bits shown against com2 |
| gp_sel_i | input | 1 | Turn the top segment group into plain outputs |
| port_i | input | PORT_SEGS | Plain output data for the top group |
| com1_lvl_o | output | 2 | Level code of common 1 |
| com2_lvl_o | output | 2 | Level code of common 2 |
| seg_o | output | NSEG | Level of each segment line (1 high, 0 low) |

## Verification
The pattern writes use all-ones, all-zeros, alternating and phase-opposed nibbles spread across several digits, including the first and last. These tell apart a swapped phase, a missing or extra inversion per slot, and a write landing on the wrong digit. A write placed in the middle of a frame separates a deferred update from an immediate one. An out-of-range index shows whether the digit decode wraps. Reset, backup and port-mode runs show that each override reaches only the pins it should, and that the stored pattern survives backup.

// File: rtl/lcd_halfbias_pkg.sv
package lcd_halfbias_pkg;
  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10
  } lvl_e;

  typedef enum logic [1:0] {
    SL_C1_HI = 2'd0,
    SL_C1_LO = 2'd1,
    SL_C2_HI = 2'd2,
    SL_C2_LO = 2'd3
  } slot_e;
endpackage

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer #(
  parameter int SLOT_CYCLES = 10
) (
  input  logic                      clk_i,
  output lcd_halfbias_pkg::slot_e   slot_o,
  output logic                      frame_end_o
);
  import lcd_halfbias_pkg::*;

  localparam int CW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOT_CYCLES - 1);

  // Free-running on purpose: the commons keep cycling through reset.
  logic [CW-1:0] cnt_q  = '0;
  slot_e         slot_q = SL_C1_HI;
  logic          slot_end;

  assign slot_end = (cnt_q == LAST);

  always_ff @(posedge clk_i) begin
    if (slot_end) begin
      cnt_q  <= '0;
      slot_q <= slot_e'(slot_q + 2'd1);
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign slot_o      = slot_q;
  assign frame_end_o = slot_end && (slot_q == SL_C2_LO);
endmodule

// File: rtl/lcd_seg_store.sv
module lcd_seg_store #(
  parameter int NDIG    = 7,
  parameter int DIGIT_W = 4,
  parameter int DIG_AW  = 3,
  localparam int NSEG   = NDIG * DIGIT_W
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               wr_en_i,
  input  logic [DIG_AW-1:0]  wr_dig_i,
  input  logic [DIGIT_W-1:0] wr_ph0_i,
  input  logic [DIGIT_W-1:0] wr_ph1_i,
  input  logic               frame_end_i,
  output logic [NSEG-1:0]    act0_o,
  output logic [NSEG-1:0]    act1_o
);
  logic [NSEG-1:0] stage0_q, stage1_q;
  logic [NSEG-1:0] act0_q, act1_q;

  for (genvar d = 0; d < NDIG; d++) begin : g_dig
    logic hit;
    assign hit = wr_en_i && (wr_dig_i == DIG_AW'(d));

    // Staging copy: written any time.
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        stage0_q[d*DIGIT_W +: DIGIT_W] <= '0;
        stage1_q[d*DIGIT_W +: DIGIT_W] <= '0;
      end else if (hit) begin
        stage0_q[d*DIGIT_W +: DIGIT_W] <= wr_ph0_i;
        stage1_q[d*DIGIT_W +: DIGIT_W] <= wr_ph1_i;
      end
    end

    // Displayed copy: refreshed only at the frame boundary.
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        act0_q[d*DIGIT_W +: DIGIT_W] <= '0;
        act1_q[d*DIGIT_W +: DIGIT_W] <= '0;
      end else if (frame_end_i) begin
        act0_q[d*DIGIT_W +: DIGIT_W] <= stage0_q[d*DIGIT_W +: DIGIT_W];
        act1_q[d*DIGIT_W +: DIGIT_W] <= stage1_q[d*DIGIT_W +: DIGIT_W];
      end
    end
  end

  assign act0_o = act0_q;
  assign act1_o = act1_q;
endmodule

// File: rtl/lcd_drive_encoder.sv
module lcd_drive_encoder #(
  parameter int NSEG      = 28,
  parameter int PORT_SEGS = 4
) (
  input  logic                     clk_i,
  input  logic                     blank_i,
  input  logic                     bkup_i,
  input  logic                     gp_sel_i,
  input  logic [PORT_SEGS-1:0]     port_i,
  input  lcd_halfbias_pkg::slot_e  slot_i,
  input  logic [NSEG-1:0]          act0_i,
  input  logic [NSEG-1:0]          act1_i,
  output logic [1:0]               com1_o,
  output logic [1:0]               com2_o,
  output logic [NSEG-1:0]          seg_o
);
  import lcd_halfbias_pkg::*;

  lvl_e            c1_n, c2_n;
  logic [NSEG-1:0] pat, lcd_n, seg_n;

  always_comb begin
    c1_n = LVL_MID;
    c2_n = LVL_MID;
    pat  = blank_i ? '0 : act0_i;
    unique case (slot_i)
      SL_C1_HI: begin c1_n = LVL_HIGH; lcd_n = ~pat; end
      SL_C1_LO: begin c1_n = LVL_LOW;  lcd_n =  pat; end
      SL_C2_HI: begin
        c2_n  = LVL_HIGH;
        pat   = blank_i ? '0 : act1_i;
        lcd_n = ~pat;
      end
      default: begin
        c2_n  = LVL_LOW;
        pat   = blank_i ? '0 : act1_i;
        lcd_n = pat;
      end
    endcase
  end

  if (PORT_SEGS > 0) begin : g_port
    always_comb begin
      seg_n = lcd_n;
      if (gp_sel_i && !blank_i)
        seg_n[NSEG-1 -: PORT_SEGS] = port_i;
    end
  end else begin : g_noport
    assign seg_n = lcd_n;
  end

  logic [1:0]      com1_q = '0;
  logic [1:0]      com2_q = '0;
  logic [NSEG-1:0] seg_q  = '0;

  always_ff @(posedge clk_i) begin
    if (bkup_i) begin
      com1_q <= LVL_LOW;
      com2_q <= LVL_LOW;
      seg_q  <= '0;
    end else begin
      com1_q <= c1_n;
      com2_q <= c2_n;
      seg_q  <= seg_n;
    end
  end

  assign com1_o = com1_q;
  assign com2_o = com2_q;
  assign seg_o  = seg_q;
endmodule

// File: rtl/lcd_halfbias_driver.sv
module lcd_halfbias_driver #(
  parameter int CLK_HZ    = 4_500_000,
  parameter int FRAME_HZ  = 100,
  parameter int NDIG      = 7,
  parameter int DIGIT_W   = 4,
  parameter int PORT_SEGS = 4,
  localparam int NSEG     = NDIG * DIGIT_W,
  localparam int DIG_AW   = (NDIG > 1) ? $clog2(NDIG) : 1,
  localparam int SLOT_CYC = CLK_HZ / (FRAME_HZ * 4),
  localparam int PW       = (PORT_SEGS > 0) ? PORT_SEGS : 1
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               bkup_i,
  input  logic               wr_en_i,
  input  logic [DIG_AW-1:0]  wr_dig_i,
  input  logic [DIGIT_W-1:0] wr_ph0_i,
  input  logic [DIGIT_W-1:0] wr_ph1_i,
  input  logic               gp_sel_i,
  input  logic [PW-1:0]      port_i,
  output logic [1:0]         com1_lvl_o,
  output logic [1:0]         com2_lvl_o,
  output logic [NSEG-1:0]    seg_o
);
  import lcd_halfbias_pkg::*;

  slot_e           slot;
  logic            frame_end;
  logic [NSEG-1:0] act0, act1;

  lcd_frame_timer #(.SLOT_CYCLES(SLOT_CYC)) u_timer (
    .clk_i       (clk_i),
    .slot_o      (slot),
    .frame_end_o (frame_end)
  );

  lcd_seg_store #(.NDIG(NDIG), .DIGIT_W(DIGIT_W), .DIG_AW(DIG_AW)) u_store (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .wr_en_i     (wr_en_i),
    .wr_dig_i    (wr_dig_i),
    .wr_ph0_i    (wr_ph0_i),
    .wr_ph1_i    (wr_ph1_i),
    .frame_end_i (frame_end),
    .act0_o      (act0),
    .act1_o      (act1)
  );

  lcd_drive_encoder #(.NSEG(NSEG), .PORT_SEGS(PW)) u_enc (
    .clk_i    (clk_i),
    .blank_i  (rst_i),
    .bkup_i   (bkup_i),
    .gp_sel_i (gp_sel_i && (PORT_SEGS > 0)),
    .port_i   (port_i),
    .slot_i   (slot),
    .act0_i   (act0),
    .act1_i   (act1),
    .com1_o   (com1_lvl_o),
    .com2_o   (com2_lvl_o),
    .seg_o    (seg_o)
  );
endmodule

// File: rtl/lcd_halfbias_checker.sv
module lcd_halfbias_checker #(
  parameter int NSEG      = 28,
  parameter int PW        = 4,
  parameter int FRAME_CYC = 40
) (
  input logic            clk_i,
  input logic            rst_i,
  input logic            bkup_i,
  input logic            gp_sel_i,
  input logic [PW-1:0]   port_i,
  input logic [1:0]      com1_lvl_o,
  input logic [1:0]      com2_lvl_o,
  input logic [NSEG-1:0] seg_o
);
  logic [1:0]  prev_c1 = 2'b00;
  logic        seen    = 1'b0;
  logic [31:0] gap     = '0;
  logic        tr;

  assign tr = (com1_lvl_o == 2'b10) && (prev_c1 != 2'b10);

  always_ff @(posedge clk_i) begin
    prev_c1 <= com1_lvl_o;
    if (bkup_i) begin
      seen <= 1'b0;
      gap  <= '0;
    end else if (tr) begin
      seen <= 1'b1;
      gap  <= '0;
    end else begin
      gap  <= gap + 1;
    end
  end

  p_frame_len_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    (tr && seen && !bkup_i) |-> (gap == FRAME_CYC - 1));

  p_legal_code_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (com1_lvl_o != 2'b11) && (com2_lvl_o != 2'b11));

  p_one_common_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (com1_lvl_o == 2'b01) || (com2_lvl_o == 2'b01) ||
    (com1_lvl_o == 2'b00 && com2_lvl_o == 2'b00));

  p_bkup_low_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    bkup_i |=> (com1_lvl_o == 2'b00 && com2_lvl_o == 2'b00 && seg_o == '0));

  p_port_pass_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (gp_sel_i && !bkup_i) |=> (seg_o[NSEG-1 -: PW] == $past(port_i)));
endmodule

bind lcd_halfbias_driver lcd_halfbias_checker #(
  .NSEG(NSEG), .PW(PW), .FRAME_CYC(CLK_HZ / FRAME_HZ)
) u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .bkup_i     (bkup_i),
  .gp_sel_i   (gp_sel_i),
  .port_i     (port_i),
  .com1_lvl_o (com1_lvl_o),
  .com2_lvl_o (com2_lvl_o),
  .seg_o      (seg_o)
);

// File: tb/test_lcd_halfbias_driver.sv
module test_lcd_halfbias_driver;
  localparam int NDIG = 7, DW = 4, NSEG = 28, PS = 4;
  localparam int SLOT = 10, FRAME = 40;
  localparam logic [1:0] LO = 2'b00, MI = 2'b01, HI = 2'b10;

  logic clk = 1'b0;
  logic rst = 1'b1, bkup = 1'b0, wr_en = 1'b0, gp = 1'b0;
  logic [2:0] wr_dig = '0;
  logic [DW-1:0] ph0 = '0, ph1 = '0;
  logic [PS-1:0] port = '0;
  logic [1:0] c1, c2;
  logic [NSEG-1:0] seg;

  int tests = 0, fails = 0;
  logic done = 1'b0;
  logic [NSEG-1:0] m0 = '0, m1 = '0;

  always #5 clk = ~clk;

  lcd_halfbias_driver #(.CLK_HZ(4000), .FRAME_HZ(100), .NDIG(NDIG),
                        .DIGIT_W(DW), .PORT_SEGS(PS)) i_lcd_halfbias_driver (
    .clk_i(clk), .rst_i(rst), .bkup_i(bkup), .wr_en_i(wr_en),
    .wr_dig_i(wr_dig), .wr_ph0_i(ph0), .wr_ph1_i(ph1), .gp_sel_i(gp),
    .port_i(port), .com1_lvl_o(c1), .com2_lvl_o(c2), .seg_o(seg));

  // digit, phase-0 nibble, phase-1 nibble
  localparam logic [10:0] VEC [6] = '{
    {3'd0, 4'hF, 4'h0}, {3'd6, 4'h0, 4'hF}, {3'd3, 4'hA, 4'h5},
    {3'd1, 4'h5, 4'h5}, {3'd0, 4'h3, 4'hC}, {3'd6, 4'h9, 4'h6}};

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sync_frame();
    logic [1:0] p;
    p = c1;
    @(negedge clk);
    while (!(c1 == HI && p != HI)) begin
      p = c1;
      @(negedge clk);
    end
  endtask

  function automatic logic [NSEG-1:0] exp_seg(int k, logic blank, logic g);
    logic [NSEG-1:0] a, r;
    a = blank ? '0 : ((k < 2) ? m0 : m1);
    r = (k % 2 == 0) ? ~a : a;
    if (g && !blank) r[NSEG-1 -: PS] = port;
    return r;
  endfunction

  // Called right after sync_frame; checks mid-slot of all four slots.
  task automatic check_frame(string req, logic blank, logic g);
    logic [1:0] e1 [4] = '{HI, LO, MI, MI};
    logic [1:0] e2 [4] = '{MI, MI, HI, LO};
    repeat (5) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      if (k > 0) repeat (SLOT) @(negedge clk);
      chk({req, " R2 com1"}, 64'(c1), 64'(e1[k]));
      chk({req, " R2 com2"}, 64'(c2), 64'(e2[k]));
      chk({req, " seg"}, 64'(seg), 64'(exp_seg(k, blank, g)));
    end
  endtask

  task automatic wr(int d, logic [3:0] a, logic [3:0] b, logic upd);
    wr_en = 1'b1; wr_dig = 3'(d); ph0 = a; ph1 = b;
    @(negedge clk);
    wr_en = 1'b0;
    if (upd && d < NDIG) begin
      m0[d*DW +: DW] = a;
      m1[d*DW +: DW] = b;
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R6: reset blanks segments, commons keep cycling
    sync_frame();
    check_frame("R6 reset off", 1'b1, 1'b0);
    // R1: slot and frame length measured at the outputs
    sync_frame();
    n = 1;
    while (c1 == HI) begin @(negedge clk); n++; end
    chk("R1 slot length", 64'(n - 1), 64'(SLOT));
    while (!(c1 == HI)) begin @(negedge clk); n++; end
    chk("R1 frame length", 64'(n - 1), 64'(FRAME));
    rst = 1'b0;
    sync_frame();
    check_frame("R6 cleared after reset", 1'b0, 1'b0);
    // R3/R4: vector table
    for (int v = 0; v < 6; v++) begin
      sync_frame();
      wr(int'(VEC[v][10:8]), VEC[v][7:4], VEC[v][3:0], 1'b1);
      sync_frame();
      check_frame("R3 R4 vector", 1'b0, 1'b0);
    end
    // R5: mid-frame write shows only from the next frame
    begin
      logic [NSEG-1:0] n0, n1;
      sync_frame();
      repeat (12) @(negedge clk);
      wr(2, 4'h6, 4'hB, 1'b0);
      repeat (12) @(negedge clk);
      chk("R5 old pattern slot2", 64'(seg), 64'(exp_seg(2, 1'b0, 1'b0)));
      repeat (10) @(negedge clk);
      chk("R5 old pattern slot3", 64'(seg), 64'(exp_seg(3, 1'b0, 1'b0)));
      n0 = m0; n1 = m1;
      n0[2*DW +: DW] = 4'h6; n1[2*DW +: DW] = 4'hB;
      m0 = n0; m1 = n1;
      sync_frame();
      check_frame("R5 new pattern", 1'b0, 1'b0);
    end
    // R9: out-of-range digit
    sync_frame();
    wr(7, 4'hF, 4'hF, 1'b1);
    sync_frame();
    check_frame("R9 ignored write", 1'b0, 1'b0);
    // R7: backup
    @(negedge clk);
    bkup = 1'b1;
    @(negedge clk);
    chk("R7 com1 low", 64'(c1), 64'(LO));
    chk("R7 com2 low", 64'(c2), 64'(LO));
    chk("R7 seg low", 64'(seg), 64'(0));
    repeat (53) @(negedge clk);
    chk("R7 seg held low", 64'({c1, c2, seg}), 64'(0));
    bkup = 1'b0;
    sync_frame();
    check_frame("R7 pattern kept", 1'b0, 1'b0);
    // R8: port mode on the top group
    port = 4'b1010; gp = 1'b1;
    sync_frame();
    check_frame("R8 port mode", 1'b0, 1'b1);
    port = 4'b0110;
    sync_frame();
    check_frame("R8 port mode b", 1'b0, 1'b1);
    gp = 1'b0;
    // R6: reset again clears pattern and blanks
    rst = 1'b1;
    sync_frame();
    check_frame("R6 reset again", 1'b1, 1'b0);
    rst = 1'b0; m0 = '0; m1 = '0;
    sync_frame();
    check_frame("R6 pattern cleared", 1'b0, 1'b0);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule